// File: doc/BRIEF.md
# Triggered Conversion Request Arbiter

This block sits between an event-driven trigger source and an analog-to-digital converter that can handle one channel at a time. Each channel has a trigger input. The block records a request per channel and hands requests to the converter one at a time. It walks the converter through an optional settling wait for an external multiplexer, then a sample phase and a convert phase. When a conversion finishes, it reports completion back to the trigger source with a one-cycle pulse tagged with the channel number.

A channel whose conversion is still in flight can hold one more request. That request is issued once the running conversion has completed, so two triggers close together on one channel are both served. Any trigger beyond that is lost. The converter can be powered down through an input. If this happens while a conversion is running, the conversion is abandoned and no completion is reported. The affected channel stays marked as in flight, so it never converts again until reset. The other channels carry on.

The phase lengths and the multiplexer delay come from inputs. The analog work itself is represented only by these cycle counts.

Top module: `adc_trig_arbiter`

## Requirements
- R1: `status_o` shows the converter phase as 3'b000 idle, 3'b001 powered down, 3'b010 multiplexer wait, 3'b100 sampling, 3'b110 converting; the codes 3'b011, 3'b101 and 3'b111 never appear.
- R2: After reset `status_o` is 3'b000 and `done_o` is 0.
- R3: When several channels are waiting while the converter is idle, they are converted in ascending channel-number order.
- R4: A trigger on a channel whose conversion is in progress is held as one buffered request and converted after the running conversion completes.
- R5: A trigger on a channel that already holds a buffered request (whether or not that channel is converting) is discarded.
- R6: The multiplexer wait phase is entered only when `mux_dly_i` is nonzero, and then lasts `mux_dly_i` cycles; with `mux_dly_i` zero the converter goes directly from idle to sampling.
- R7: Sampling lasts `smp_len_i` cycles and converting lasts `cnv_len_i` cycles, a value of zero counting as one; a trigger on an idle converter with `mux_dly_i` zero shows sampling two cycles after the trigger is presented.
- R8: At the end of the convert phase `done_o` is high for exactly one cycle, with `done_ch_o` giving the converted channel, as `status_o` returns to idle.
- R9: `pwr_dn_i` taken while idle moves `status_o` to 3'b001 on the next cycle; releasing it returns `status_o` to 3'b000 on the next cycle.
- R10: `pwr_dn_i` during a wait, sample or convert phase moves to powered down with no `done_o` for that channel. That channel then produces no completion until reset, while other channels are still converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | NUM_CH | Per-channel conversion trigger, one cycle per request |
| mux_dly_i | input | CNT_W | Multiplexer settling cycles, 0 skips the wait |
| smp_len_i | input | CNT_W | Sample phase length in cycles |
| cnv_len_i | input | CNT_W | Convert phase length in cycles |
| pwr_dn_i | input | 1 | Converter power-down request (level) |
| status_o | output | 3 | Converter phase code |
| done_o | output | 1 | Completion pulse to the trigger source |
| done_ch_o | output | $clog2(NUM_CH) | Channel of the completed conversion |

## Verification
The hardest case to reach is a power-down that lands exactly inside a triggered conversion. It leaves one channel permanently marked as in flight, and only the absence of later completions shows this. The stimulus waits until the status shows the convert phase, then raises power-down. It triggers the same channel again and watches a long window with no completion. It then triggers another channel to show that arbitration still serves the remaining channels. The buffered-request case is reached by re-triggering a channel while its own conversion is sampling, then triggering it twice more during conversion, and counting the completions that come back.

// File: rtl/adc_arb_pkg.sv
package adc_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_OFF  = 3'b001,
    ST_MUXW = 3'b010,
    ST_SAMP = 3'b100,
    ST_CONV = 3'b110
  } conv_state_e;
endpackage

// File: rtl/arb_chan_slot.sv
module arb_chan_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic grant,
  input  logic finish,
  output logic ready
);
  logic active_q, pend_q;
  logic active_d, pend_d;

  always_comb begin
    active_d = active_q;
    pend_d   = pend_q;
    if (grant) begin
      active_d = 1'b1;
      pend_d   = trig;
    end else begin
      if (finish) active_d = 1'b0;
      if (trig && !pend_q) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      pend_q   <= pend_d;
    end
  end

  assign ready = pend_q && !active_q;

  // R5: a full slot keeps its single buffered request and drops the trigger
  p_drop_extra_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && trig && !grant) |=> pend_q);
  // R4: a trigger during a running conversion is buffered
  p_buffer_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !finish && !pend_q && trig && !grant) |=> (pend_q && active_q));
  p_grant_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ready);
endmodule

// File: rtl/arb_low_pick.sv
module arb_low_pick #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  output logic              any,
  output logic [CH_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = CH_W'(i);
      end
    end
  end

  // R3: the chosen channel has no lower requesting neighbour
  always_comb begin
    if (any) begin
      a_lowest_r3: assert ((req & ((NUM_CH'(1) << idx) - NUM_CH'(1))) == '0);
    end
  end
endmodule

// File: rtl/arb_conv_fsm.sv
module arb_conv_fsm
  import adc_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_any,
  input  logic [CH_W-1:0]  req_idx,
  input  logic [CNT_W-1:0] mux_dly,
  input  logic [CNT_W-1:0] smp_len,
  input  logic [CNT_W-1:0] cnv_len,
  input  logic             pwr_dn,
  output logic             start,
  output logic             fin,
  output logic [CH_W-1:0]  cur_ch,
  output logic [2:0]       status,
  output logic             done,
  output logic [CH_W-1:0]  done_ch
);
  conv_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  ch_q;
  logic             done_q;
  logic [CH_W-1:0]  dch_q;

  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - CNT_W'(1);
  endfunction

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start   = 1'b0;
    fin     = 1'b0;
    if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    case (state_q)
      ST_IDLE: begin
        if (pwr_dn) begin
          state_d = ST_OFF;
        end else if (req_any) begin
          start = 1'b1;
          if (mux_dly != '0) begin
            state_d = ST_MUXW;
            cnt_d   = span(mux_dly);
          end else begin
            state_d = ST_SAMP;
            cnt_d   = span(smp_len);
          end
        end
      end
      ST_MUXW, ST_SAMP, ST_CONV: begin
        if (pwr_dn) begin
          state_d = ST_OFF;
          cnt_d   = '0;
        end else if (cnt_q == '0) begin
          if (state_q == ST_MUXW) begin
            state_d = ST_SAMP;
            cnt_d   = span(smp_len);
          end else if (state_q == ST_SAMP) begin
            state_d = ST_CONV;
            cnt_d   = span(cnv_len);
          end else begin
            state_d = ST_IDLE;
            fin     = 1'b1;
          end
        end
      end
      ST_OFF: begin
        cnt_d = '0;
        if (!pwr_dn) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      done_q  <= 1'b0;
      dch_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= fin;
      if (start) ch_q  <= req_idx;
      if (fin)   dch_q <= ch_q;
    end
  end

  assign cur_ch  = ch_q;
  assign status  = state_q;
  assign done    = done_q;
  assign done_ch = dch_q;

  p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'b000 || status == 3'b001 || status == 3'b010 ||
     status == 3'b100 || status == 3'b110));
  p_no_wait_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !pwr_dn && req_any && mux_dly == '0) |=> (status == 3'b100));
  p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && pwr_dn) |=> (status == 3'b001));
  p_done_after_conv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state_q) == ST_CONV && state_q == ST_IDLE));
  p_no_done_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_OFF && pwr_dn) |=> !done);
endmodule

// File: rtl/adc_trig_arbiter.sv
module adc_trig_arbiter #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] trig_i,
  input  logic [CNT_W-1:0]  mux_dly_i,
  input  logic [CNT_W-1:0]  smp_len_i,
  input  logic [CNT_W-1:0]  cnv_len_i,
  input  logic              pwr_dn_i,
  output logic [2:0]        status_o,
  output logic              done_o,
  output logic [CH_W-1:0]   done_ch_o
);
  logic [NUM_CH-1:0] ready_v;
  logic              req_any;
  logic [CH_W-1:0]   req_idx;
  logic              start, fin;
  logic [CH_W-1:0]   cur_ch;

  arb_low_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req (ready_v),
    .any (req_any),
    .idx (req_idx)
  );

  arb_conv_fsm #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_any (req_any),
    .req_idx (req_idx),
    .mux_dly (mux_dly_i),
    .smp_len (smp_len_i),
    .cnv_len (cnv_len_i),
    .pwr_dn  (pwr_dn_i),
    .start   (start),
    .fin     (fin),
    .cur_ch  (cur_ch),
    .status  (status_o),
    .done    (done_o),
    .done_ch (done_ch_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    arb_chan_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (trig_i[g]),
      .grant  (start && (req_idx == CH_W'(g))),
      .finish (fin && (cur_ch == CH_W'(g))),
      .ready  (ready_v[g])
    );
  end
endmodule

// File: tb/tb_adc_trig_arbiter.sv
`timescale 1ns/1ps
module tb_adc_trig_arbiter;
  localparam int NUM_CH = 8;
  localparam int CNT_W  = 8;
  localparam int CH_W   = $clog2(NUM_CH);

  logic clk = 1'b0;
  logic rst_n;
  logic [NUM_CH-1:0] trig_i;
  logic [CNT_W-1:0] mux_dly_i, smp_len_i, cnv_len_i;
  logic pwr_dn_i;
  logic [2:0] status_o;
  logic done_o;
  logic [CH_W-1:0] done_ch_o;

  always #2 clk = ~clk;

  adc_trig_arbiter #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dut (.*);

  int n_chk = 0, n_fail = 0, illegal = 0;
  int exp_q[$];
  bit done_prev = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (!(status_o inside {3'b000, 3'b001, 3'b010, 3'b100, 3'b110})) illegal++;
      if (done_o) begin
        if (done_prev) chk(0, "R8 pulse width", 2, 1);
        if (exp_q.size() == 0) chk(0, "R5/R10 unexpected completion", int'(done_ch_o), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(done_ch_o) == e, "R3/R8 completion channel", int'(done_ch_o), e);
        end
      end
      done_prev = done_o;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fire(input int ch);
    trig_i[ch] = 1'b1;
    tick();
    trig_i = '0;
  endtask

  task automatic measure(input logic [2:0] code, output int n);
    n = 0;
    while (status_o == code && n < 1000) begin
      n++;
      tick();
    end
  endtask

  task automatic wait_status(input logic [2:0] code);
    int t = 0;
    while (status_o != code && t < 1000) begin
      t++;
      tick();
    end
  endtask

  initial begin
    #(200000 * 4);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    rst_n = 0; trig_i = '0; pwr_dn_i = 0;
    mux_dly_i = 0; smp_len_i = 6; cnv_len_i = 12;
    tick(3);
    chk(status_o == 3'b000, "R2 reset status", status_o, 0);
    chk(done_o == 0, "R2 reset done", done_o, 0);
    rst_n = 1;
    tick(2);

    // R7 latency and phase lengths, R8 completion
    exp_q.push_back(3);
    trig_i[3] = 1'b1; tick(); trig_i = '0;
    chk(status_o == 3'b000, "R7 latency first cycle", status_o, 0);
    tick();
    chk(status_o == 3'b100, "R7 sampling after two cycles", status_o, 3'b100);
    measure(3'b100, n);
    chk(n == 6, "R7 sample length", n, 6);
    chk(status_o == 3'b110, "R1 convert code", status_o, 3'b110);
    measure(3'b110, n);
    chk(n == 12, "R7 convert length", n, 12);
    chk(status_o == 3'b000 && done_o, "R8 done with idle", {status_o, done_o}, 1);
    tick();
    chk(done_o == 0, "R8 one-cycle pulse", done_o, 0);
    tick(3);

    // R6 multiplexer wait, zero sample length counts as one
    mux_dly_i = 4; smp_len_i = 0; cnv_len_i = 3;
    exp_q.push_back(0);
    fire(0); tick();
    chk(status_o == 3'b010, "R6 wait entered", status_o, 3'b010);
    measure(3'b010, n);
    chk(n == 4, "R6 wait length", n, 4);
    measure(3'b100, n);
    chk(n == 1, "R7 zero sample length", n, 1);
    measure(3'b110, n);
    chk(n == 3, "R7 short convert", n, 3);
    tick(3);
    mux_dly_i = 0; smp_len_i = 6; cnv_len_i = 12;

    // R3 ascending order
    exp_q.push_back(1); exp_q.push_back(5); exp_q.push_back(6);
    trig_i[5] = 1; trig_i[1] = 1; trig_i[6] = 1; tick(); trig_i = '0;
    tick(80);
    chk(exp_q.size() == 0, "R3 all served in order", exp_q.size(), 0);

    // R4 buffer one, R5 drop extras
    exp_q.push_back(2); exp_q.push_back(2);
    fire(2); tick(3);
    chk(status_o == 3'b100, "R4 first conversion sampling", status_o, 3'b100);
    fire(2);
    wait_status(3'b110);
    fire(2); tick(2); fire(2);
    tick(80);
    chk(exp_q.size() == 0, "R4 buffered request served", exp_q.size(), 0);
    chk(status_o == 3'b000, "R5 extras dropped, idle", status_o, 0);

    // R5 pending-but-waiting channel drops a second trigger
    exp_q.push_back(1); exp_q.push_back(4);
    trig_i[1] = 1; trig_i[4] = 1; tick(); trig_i = '0;
    tick(); fire(4);
    tick(80);
    chk(exp_q.size() == 0, "R5 waiting channel keeps one request", exp_q.size(), 0);

    // R9 idle power-down
    pwr_dn_i = 1; tick();
    chk(status_o == 3'b001, "R9 idle power-down", status_o, 3'b001);
    tick(2);
    chk(status_o == 3'b001, "R9 held down", status_o, 3'b001);
    pwr_dn_i = 0; tick();
    chk(status_o == 3'b000, "R9 release to idle", status_o, 0);
    tick(2);

    // R10 power-down mid conversion
    fire(4);
    wait_status(3'b110);
    tick(2);
    pwr_dn_i = 1; tick();
    chk(status_o == 3'b001, "R10 abort to power-down", status_o, 3'b001);
    chk(done_o == 0, "R10 no completion", done_o, 0);
    tick();
    pwr_dn_i = 0; tick();
    chk(status_o == 3'b000, "R10 back to idle", status_o, 0);
    fire(4);
    tick(60);
    chk(status_o == 3'b000, "R10 stuck channel not converted", status_o, 0);
    fire(4);
    tick(60);
    exp_q.push_back(0);
    fire(0);
    tick(60);
    chk(exp_q.size() == 0, "R10 other channel still served", exp_q.size(), 0);

    chk(illegal == 0, "R1 no reserved status codes", illegal, 0);
    finish_run();
  end
endmodule